// File: doc/BRIEF.md
# Programmable Serial Pointer Stop-Boundary Controller

This block models the serial access side of a dual-port video memory. It keeps an 8-bit serial pointer that addresses a 256-location serial register and steps it by one location each time the serial advance input is sampled high. Software can split the serial register into equal partitions. When the pointer leaves the last location of a partition, it jumps to a start address written in advance. If no such address is pending, it runs on into the next partition. Each partition crossing raises a one-cycle pulse.

The partition size is programmed through the control strobes. On a falling edge of the row strobe, with the column strobe low, two further control levels select one of two commands. One command arms stop mode and captures a thermometer-style code from four address bits. The other command disarms stop mode. Stop mode stays armed across any number of boundaries until the disarm command arrives. All strobes are sampled on the block clock, and the row-strobe edge is found by comparing each sample with the registered sample from the cycle before.

Top module: `serial_stop_ctrl`

## Requirements
- R1: After a synchronous reset, `ser_ptr` is 0, `bnd_pulse` is 0 and `stop_active` is 0.
- R2: A set command is recognised only when `row_stb_n` was sampled high on one clock and is sampled low on the next, with `col_stb_n`=0, `wr_stb_n`=0 and `func_sel`=1 on that second clock. `stop_active` is then 1 from the following cycle. If `row_stb_n` stays low while the other levels change to the set pattern, nothing happens.
- R3: The set command captures code c = `addr[7:4]`, where c[0] is `addr[4]`. The lowest zero bit of c picks the partition size: c[0]=0 gives 16, c[1:0]=01 gives 32, c[2:0]=011 gives 64, c=0111 gives 128 and c=1111 gives 256. `addr[3:0]` and `addr[8]` have no effect.
- R4: A clear command uses the same edge with `col_stb_n`=0, `wr_stb_n`=1 and `func_sel`=0. It sets `stop_active` to 0 from the next cycle. An edge with `col_stb_n`=1 changes nothing.
- R5: While stop mode is off, each sampled `ser_adv` increments `ser_ptr` modulo 256 and `bnd_pulse` stays 0.
- R6: While stop mode is on, an advance taken when the pointer bits below the partition size are all ones loads the pending start address into `ser_ptr` and raises `bnd_pulse` for exactly that one cycle.
- R7: At such a crossing with no start address pending, `ser_ptr` increments into the next partition and `bnd_pulse` is still raised.
- R8: A crossing uses up the pending start address. A `start_wr` in the same cycle as a crossing leaves its new address pending, and the crossing takes the old address.
- R9: Stop mode stays on across any number of crossings. A later set command replaces the partition size.
- R10: `ser_ptr` changes only on a clock where `ser_adv` is sampled high, and the new value is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| row_stb_n | input | 1 | Row strobe, active low; its falling edge qualifies commands |
| col_stb_n | input | 1 | Column strobe, active low; must be low for a command |
| wr_stb_n | input | 1 | Write strobe level; low selects set, high selects clear |
| func_sel | input | 1 | Function select level; high selects set, low selects clear |
| addr | input | 9 | Address bus; bits 7:4 carry the partition code |
| ser_adv | input | 1 | Serial clock enable; one pointer step per sampled high |
| start_wr | input | 1 | Writes `start_addr` as the pending start address |
| start_addr | input | 8 | Start address used at the next partition crossing |
| ser_ptr | output | 8 | Current serial pointer |
| bnd_pulse | output | 1 | One-cycle pulse on each partition crossing |
| stop_active | output | 1 | Stop mode armed |

## Verification
Embedded assertions check on every cycle the cycle-level rules: a command arms or disarms the mode on the next cycle, the mode holds steady without a command, the captured mask always has a legal shape, the pointer holds when there is no advance and counts freely while the mode is off, and a pulse only follows an advance taken in stop mode. Only the directed scenarios can show the behaviour that depends on values and history. These are: the partition size decoded from each code, the exact location where the pointer jumps, whether a pending start address is used up, a start write that collides with a crossing, and strobe sequences where only the level changes with no falling edge.

// File: rtl/serstop_pkg.sv
// Package: shared types for the serial stop-boundary controller.
// Assumes a single clock domain; all strobes arrive already sampled-safe.
package serstop_pkg;

    // Command decoded from one row-strobe falling edge.
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ARM   = 2'd1,
        CMD_DISARM = 2'd2
    } stop_cmd_e;

endpackage

// File: rtl/stb_cmd_decode.sv
// Module: stb_cmd_decode
// Finds a falling edge of the row strobe by comparing the current sample
// with the registered previous one, and classifies the command from the
// other strobe levels sampled on the same clock. Assumes inputs are
// synchronous to clk.
module stb_cmd_decode
    import serstop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      row_stb_n,
    input  logic      col_stb_n,
    input  logic      wr_stb_n,
    input  logic      func_sel,
    output stop_cmd_e cmd
);

    logic row_prev;
    logic row_fall;

    // Purpose: remember last row-strobe sample (idle high after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) row_prev <= 1'b1;
        else        row_prev <= row_stb_n;
    end

    assign row_fall = row_prev & ~row_stb_n;

    // Purpose: classify the command present at a row-strobe falling edge.
    always_comb begin
        cmd = CMD_NONE;
        if (row_fall && !col_stb_n) begin
            if (!wr_stb_n && func_sel)      cmd = CMD_ARM;
            else if (wr_stb_n && !func_sel) cmd = CMD_DISARM;
        end
    end

    // An edge cannot be seen twice in a row: row strobe is low after it.
    AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NONE) |=> (cmd == CMD_NONE)); // R2

endmodule

// File: rtl/stop_mode_reg.sv
// Module: stop_mode_reg
// Holds the stop-mode flag and the partition mask. An arm command latches
// the thermometer code from the address bus and turns it into a mask
// of low pointer bits; a disarm command drops the flag. Assumes
// PTR_W > CODE_W so the smallest partition has at least two locations.
module stop_mode_reg
    import serstop_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter int ADDR_W   = 9,
    parameter int CODE_LSB = 4,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stop_cmd_e         cmd,
    input  logic [ADDR_W-1:0] addr,
    output logic              stop_active,
    output logic [PTR_W-1:0]  part_mask
);

    localparam int MIN_LOG = PTR_W - CODE_W;

    logic [CODE_W-1:0] code;

    assign code = addr[CODE_LSB +: CODE_W];

    // Purpose: the lowest zero bit of the code sets log2 of partition size.
    function automatic logic [PTR_W-1:0] code_to_mask(input logic [CODE_W-1:0] c);
        int   lg;
        logic found;
        logic [PTR_W-1:0] m;
        lg    = PTR_W;
        found = 1'b0;
        for (int i = 0; i < CODE_W; i++) begin
            if (!found && !c[i]) begin
                lg    = MIN_LOG + i;
                found = 1'b1;
            end
        end
        for (int b = 0; b < PTR_W; b++) m[b] = (b < lg);
        return m;
    endfunction

    // Purpose: update mode flag and mask on arm / disarm commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_active <= 1'b0;
            part_mask   <= '1;
        end else begin
            case (cmd)
                CMD_ARM: begin
                    stop_active <= 1'b1;
                    part_mask   <= code_to_mask(code);
                end
                CMD_DISARM: stop_active <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ARM) |=> stop_active); // R2
    AST_DISARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DISARM) |=> !stop_active); // R4
    AST_MODE_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE) |=> $stable(stop_active)); // R9
    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (&part_mask[MIN_LOG-1:0]) && (((part_mask + 1'b1) & part_mask) == '0)); // R3

endmodule

// File: rtl/ser_ptr_ctrl.sv
// Module: ser_ptr_ctrl
// Serial pointer with a pending start address. Each sampled advance steps
// the pointer; in stop mode, leaving the last location of a partition loads
// the pending start address (if one is held) and pulses the crossing output.
// Assumes part_mask is a run of low ones.
module ser_ptr_ctrl #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_adv,
    input  logic             start_wr,
    input  logic [PTR_W-1:0] start_addr,
    input  logic             stop_active,
    input  logic [PTR_W-1:0] part_mask,
    output logic [PTR_W-1:0] ser_ptr,
    output logic             bnd_pulse
);

    logic [PTR_W-1:0] pend_addr;
    logic             pend_vld;
    logic             at_last;
    logic             crossing;

    assign at_last  = stop_active && ((ser_ptr & part_mask) == part_mask);
    assign crossing = ser_adv && at_last;

    // Purpose: step or reload the pointer on each sampled advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_ptr <= '0;
        end else if (ser_adv) begin
            if (crossing && pend_vld) ser_ptr <= pend_addr;
            else                      ser_ptr <= ser_ptr + 1'b1;
        end
    end

    // Purpose: hold the pending start address until a crossing uses it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_vld  <= 1'b0;
        end else if (start_wr) begin
            pend_addr <= start_addr;
            pend_vld  <= 1'b1;
        end else if (crossing) begin
            pend_vld  <= 1'b0;
        end
    end

    // Purpose: one-cycle crossing pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) bnd_pulse <= 1'b0;
        else        bnd_pulse <= crossing;
    end

    AST_FREE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_adv && !stop_active) |=> (ser_ptr == PTR_W'($past(ser_ptr) + 1'b1))); // R5
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_pulse |-> $past(ser_adv && stop_active)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_adv |=> $stable(ser_ptr)); // R10
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_adv |=> !bnd_pulse); // R6

endmodule

// File: rtl/serial_stop_ctrl.sv
// Module: serial_stop_ctrl (top)
// Serial pointer with programmable stop boundaries. Strobe commands arm
// or disarm stop mode and pick the partition size; the pointer reloads
// from a pending start address at each partition crossing.
// Assumes all inputs are synchronous to clk.
module serial_stop_ctrl
    import serstop_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter int ADDR_W   = 9,
    parameter int CODE_LSB = 4,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              wr_stb_n,
    input  logic              func_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ser_adv,
    input  logic              start_wr,
    input  logic [PTR_W-1:0]  start_addr,
    output logic [PTR_W-1:0]  ser_ptr,
    output logic              bnd_pulse,
    output logic              stop_active
);

    stop_cmd_e        cmd;
    logic [PTR_W-1:0] part_mask;

    stb_cmd_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .wr_stb_n  (wr_stb_n),
        .func_sel  (func_sel),
        .cmd       (cmd)
    );

    stop_mode_reg #(
        .PTR_W    (PTR_W),
        .ADDR_W   (ADDR_W),
        .CODE_LSB (CODE_LSB),
        .CODE_W   (CODE_W)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .addr        (addr),
        .stop_active (stop_active),
        .part_mask   (part_mask)
    );

    ser_ptr_ctrl #(
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_adv     (ser_adv),
        .start_wr    (start_wr),
        .start_addr  (start_addr),
        .stop_active (stop_active),
        .part_mask   (part_mask),
        .ser_ptr     (ser_ptr),
        .bnd_pulse   (bnd_pulse)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (ser_ptr == '0 && !bnd_pulse && !stop_active)); // R1

endmodule

// File: tb/serial_stop_ctrl_tb.sv
module serial_stop_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       row_stb_n, col_stb_n, wr_stb_n, func_sel;
    logic [8:0] addr;
    logic       ser_adv, start_wr;
    logic [7:0] start_addr;
    logic [7:0] ser_ptr;
    logic       bnd_pulse, stop_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_stop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .wr_stb_n(wr_stb_n), .func_sel(func_sel), .addr(addr),
        .ser_adv(ser_adv), .start_wr(start_wr), .start_addr(start_addr),
        .ser_ptr(ser_ptr), .bnd_pulse(bnd_pulse), .stop_active(stop_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        row_stb_n = 1; col_stb_n = 1; wr_stb_n = 1; func_sel = 0;
        addr = '0; ser_adv = 0; start_wr = 0; start_addr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // One row-strobe falling edge with the given levels, then back to idle.
    task automatic strobe(input logic c, input logic w, input logic f, input logic [8:0] a);
        row_stb_n = 1;
        @(negedge clk);
        row_stb_n = 0; col_stb_n = c; wr_stb_n = w; func_sel = f; addr = a;
        @(negedge clk);
        row_stb_n = 1; col_stb_n = 1; wr_stb_n = 1; func_sel = 0; addr = '0;
        @(negedge clk);
    endtask

    task automatic write_start(input logic [7:0] a);
        start_wr = 1; start_addr = a;
        @(negedge clk);
        start_wr = 0;
    endtask

    // Advance n times; report pulse count and the step of the first pulse.
    task automatic steps(input int n, output int npulse, output int first_at);
        npulse = 0; first_at = -1;
        for (int i = 0; i < n; i++) begin
            ser_adv = 1;
            @(negedge clk);
            if (bnd_pulse) begin
                if (first_at < 0) first_at = i + 1;
                npulse++;
            end
        end
        ser_adv = 0;
        @(negedge clk);
        chk(!bnd_pulse, "R6 pulse clears", int'(bnd_pulse), 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(ser_ptr == 0, "R1 ptr", ser_ptr, 0);
        chk(!bnd_pulse, "R1 pulse", bnd_pulse, 0);
        chk(!stop_active, "R1 mode", stop_active, 0);
    endtask

    task automatic t_free_run();
        int np, fa;
        do_reset();
        steps(300, np, fa);
        chk(np == 0, "R5 no pulses", np, 0);
        chk(ser_ptr == 8'd44, "R5 wrap count", ser_ptr, 44);
        repeat (3) @(negedge clk);
        chk(ser_ptr == 8'd44, "R10 hold", ser_ptr, 44);
    endtask

    task automatic t_codes();
        logic [3:0] code [5];
        int size [5];
        int np, fa;
        code[0] = 4'b1110; size[0] = 16;
        code[1] = 4'b1101; size[1] = 32;
        code[2] = 4'b1011; size[2] = 64;
        code[3] = 4'b0111; size[3] = 128;
        code[4] = 4'b1111; size[4] = 256;
        for (int k = 0; k < 5; k++) begin
            do_reset();
            strobe(0, 0, 1, {k[0], code[k], 4'(k * 3 + 5)});
            chk(stop_active, "R2 set arms", stop_active, 1);
            steps(size[k], np, fa);
            chk(fa == size[k], "R3 partition size", fa, size[k]);
            chk(ser_ptr == 8'(size[k]), "R7 continue", ser_ptr, size[k] % 256);
        end
    endtask

    task automatic t_jump();
        int np, fa;
        do_reset();
        strobe(0, 0, 1, 9'h10E);
        write_start(8'h40);
        steps(16, np, fa);
        chk(fa == 16 && np == 1, "R6 crossing pulse", fa, 16);
        chk(ser_ptr == 8'h40, "R6 reload", ser_ptr, 8'h40);
        steps(16, np, fa);
        chk(np == 1, "R7 pulse without pending", np, 1);
        chk(ser_ptr == 8'h50, "R8 pending used once", ser_ptr, 8'h50);
    endtask

    task automatic t_collide();
        int np, fa;
        do_reset();
        strobe(0, 0, 1, 9'h000);
        write_start(8'h40);
        steps(15, np, fa);
        chk(ser_ptr == 8'd15 && np == 0, "R8 setup", ser_ptr, 15);
        ser_adv = 1; start_wr = 1; start_addr = 8'h80;
        @(negedge clk);
        ser_adv = 0; start_wr = 0;
        chk(ser_ptr == 8'h40, "R8 old address taken", ser_ptr, 8'h40);
        chk(bnd_pulse, "R8 pulse", bnd_pulse, 1);
        steps(16, np, fa);
        chk(ser_ptr == 8'h80, "R8 new address kept", ser_ptr, 8'h80);
    endtask

    task automatic t_persist_clear();
        int np, fa;
        do_reset();
        strobe(0, 0, 1, 9'h000);
        steps(64, np, fa);
        chk(np == 4, "R9 repeated crossings", np, 4);
        chk(stop_active, "R9 still armed", stop_active, 1);
        strobe(1, 1, 0, 9'h000);
        chk(stop_active, "R4 col high ignored", stop_active, 1);
        strobe(0, 0, 1, 9'h0F0);
        steps(64, np, fa);
        chk(np == 0, "R9 size replaced", np, 0);
        strobe(0, 1, 0, 9'h000);
        chk(!stop_active, "R4 clear", stop_active, 0);
        steps(200, np, fa);
        chk(np == 0, "R4 no crossings after clear", np, 0);
    endtask

    task automatic t_level_only();
        do_reset();
        row_stb_n = 1;
        @(negedge clk);
        row_stb_n = 0; col_stb_n = 1; wr_stb_n = 0; func_sel = 1;
        @(negedge clk);
        col_stb_n = 0;
        repeat (2) @(negedge clk);
        chk(!stop_active, "R2 no edge no arm", stop_active, 0);
        row_stb_n = 1;
        @(negedge clk);
        row_stb_n = 0;
        @(negedge clk);
        chk(stop_active, "R2 edge arms", stop_active, 1);
        idle_inputs();
        @(negedge clk);
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        t_reset();
        t_free_run();
        t_codes();
        t_jump();
        t_collide();
        t_persist_clear();
        t_level_only();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule